// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This unit watches the eight already-synchronized input pins of one GPIO port and turns selected pin activity into interrupt requests. Each pin has its own trigger kind (rising edge, falling edge, either edge, high level or low level), its own enable bit and its own status bit. Software reaches the unit over a simple register bus: it programs the trigger kinds and enables, reads the status, and acknowledges pins by writing ones to a clear location. One combined request line goes high while any pin is both pending and enabled.

The trigger kind is spread over three byte lanes of a single 24-bit register. For pin n, bit n is the polarity (1 = high level or rising edge), bit 8+n chooses edge (1) or level (0), and bit 16+n chooses both edges. Enable and the polarity lane each also have a masked-write alias that changes only the pins whose mask bit is set, so two agents can update different pins without a read-modify-write.

Each pin is a two-state machine. SENSE_IDLE goes to SENSE_PEND on a trigger hit (take "hit"). From SENSE_PEND an edge pin returns to SENSE_IDLE only on a clear with no hit in the same cycle (take "acknowledge"); a level pin returns to SENSE_IDLE as soon as its level is inactive (take "release"). All other cycles hold the state.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, enable reads 0x00, status reads 0x00, the type register reads 0x00FFFF (every pin rising edge) and irq_o is low.
- R2: A rising-edge pin (lanes 16/8/0 = 0/1/1) sets its status bit on the clock edge at which its input is first seen high after being low, and the bit stays set when the pin falls again.
- R3: A falling-edge pin (0/1/0) sets status on a high-to-low change and ignores a low-to-high change.
- R4: A both-edges pin (1/1/0) sets status on either change of its input.
- R5: A level pin (x/0/p) has status equal to "input equals p" sampled on the previous edge; a clear to that pin while the level is still active leaves status set.
- R6: Writing the clear register at offset 0x70 clears each status bit whose written bit is 1, leaves bits written 0 unchanged, and a new edge on the same clock as its clear leaves the bit set.
- R7: irq_o is high exactly when some pin has status and enable both 1; status still sets for a pin whose enable is 0.
- R8: A write to the enable alias at UPPER_OFS+0x50 sets enable bit n to data bit n only where data bit 8+n is 1; other enable bits keep their value.
- R9: A write to the type alias at UPPER_OFS+0x60 changes only the polarity lane (bits 7:0), bit n taking data bit n where data bit 8+n is 1; lanes 8 and 16 keep their value.
- R10: Enable reads back at 0x50 and the 24-bit type at 0x60; status (0x40) ignores writes; the clear and alias addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | 3*NPINS | Write data |
| bus_rdata | output | 3*NPINS | Read data for bus_addr, combinational |
| irq_o | output | 1 | Combined port interrupt request |

## Verification
The trigger logic is driven with single-pin rise and fall sequences under each of the five trigger kinds, so a swapped lane or inverted polarity shows as a status bit that sets on the wrong change or not at all. Level pins are held active across a clear and then released, which separates a level status from a sticky one. A clear landing together with a fresh edge, and a clear with zero bits, separate correct acknowledge priority from a plain write-one-to-clear. Masked writes carry value bits outside the mask, so a mask that is ignored or applied to the wrong lane changes the read-back.

// File: rtl/gsu_pkg.sv
package gsu_pkg;

    // Register offsets inside the port window
    localparam int OFS_STAT = 'h40;
    localparam int OFS_ENB  = 'h50;
    localparam int OFS_TYPE = 'h60;
    localparam int OFS_CLR  = 'h70;

    // Per-pin sense state
    typedef enum logic {
        SENSE_IDLE = 1'b0,
        SENSE_PEND = 1'b1
    } sense_state_e;

    // Per-pin trigger configuration gathered from the three lanes
    typedef struct packed {
        logic both;      // lane 16: either edge
        logic edge_sel;  // lane 8: edge (1) or level (0)
        logic pol;       // lane 0: high/rising (1) or low/falling (0)
    } trig_cfg_t;

endpackage

// File: rtl/gsu_regs.sv
module gsu_regs #(
    parameter int NPINS     = 8,
    parameter int ADDR_W    = 12,
    parameter int UPPER_OFS = 'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3*NPINS-1:0]   bus_wdata,
    input  logic [NPINS-1:0]     status,
    output logic [3*NPINS-1:0]   bus_rdata,
    output logic [NPINS-1:0]     enable_q,
    output logic [3*NPINS-1:0]   type_q,
    output logic [NPINS-1:0]     clr_vec
);
    import gsu_pkg::*;

    localparam int DW = 3 * NPINS;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_ENB  = ADDR_W'(OFS_ENB);
    localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(OFS_TYPE);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_MENB = ADDR_W'(UPPER_OFS + OFS_ENB);
    localparam logic [ADDR_W-1:0] A_MTYP = ADDR_W'(UPPER_OFS + OFS_TYPE);
    localparam logic [DW-1:0] TYPE_RST = {{NPINS{1'b0}}, {NPINS{1'b1}}, {NPINS{1'b1}}};

    logic [NPINS-1:0] wmask;
    logic [NPINS-1:0] wval;

    assign wmask = bus_wdata[2*NPINS-1:NPINS];
    assign wval  = bus_wdata[NPINS-1:0];

    // Write-one-to-clear strobes, valid only in the write cycle
    always_comb begin
        clr_vec = '0;
        if (bus_wr && bus_addr == A_CLR) begin
            clr_vec = wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            type_q   <= TYPE_RST;
        end else if (bus_wr) begin
            if (bus_addr == A_ENB) begin
                enable_q <= wval;
            end else if (bus_addr == A_TYPE) begin
                type_q <= bus_wdata;
            end else if (bus_addr == A_MENB) begin
                enable_q <= (enable_q & ~wmask) | (wval & wmask);
            end else if (bus_addr == A_MTYP) begin
                type_q[NPINS-1:0] <= (type_q[NPINS-1:0] & ~wmask) | (wval & wmask);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT) begin
            bus_rdata = DW'(status);
        end else if (bus_addr == A_ENB) begin
            bus_rdata = DW'(enable_q);
        end else if (bus_addr == A_TYPE) begin
            bus_rdata = type_q;
        end
    end

endmodule

// File: rtl/gsu_sense_cell.sv
module gsu_sense_cell (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_i,
    input  gsu_pkg::trig_cfg_t  cfg,
    input  logic                clr,
    output logic                pend
);
    import gsu_pkg::*;

    sense_state_e state_q, state_d;
    logic prev_q;
    logic rise, fall, hit;

    // Edge detect against the previous clock's sample
    always_comb begin
        rise = pin_i & ~prev_q;
        fall = ~pin_i & prev_q;
        if (cfg.edge_sel) begin
            if (cfg.both) begin
                hit = rise | fall;
            end else begin
                hit = cfg.pol ? rise : fall;
            end
        end else begin
            hit = (pin_i == cfg.pol);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SENSE_IDLE: begin
                if (hit) state_d = SENSE_PEND;        // take: hit
            end
            SENSE_PEND: begin
                if (cfg.edge_sel) begin
                    if (clr && !hit) state_d = SENSE_IDLE; // take: acknowledge
                end else begin
                    if (!hit) state_d = SENSE_IDLE;        // take: release
                end
            end
            default: state_d = SENSE_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SENSE_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= pin_i;
        end
    end

    // Outputs
    always_comb begin
        pend = (state_q == SENSE_PEND);
    end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int NPINS     = 8,
    parameter int ADDR_W    = 12,
    parameter int UPPER_OFS = 'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pin_i,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3*NPINS-1:0]   bus_wdata,
    output logic [3*NPINS-1:0]   bus_rdata,
    output logic                 irq_o
);
    import gsu_pkg::*;

    logic [NPINS-1:0]   status_q;
    logic [NPINS-1:0]   enable_q;
    logic [3*NPINS-1:0] type_q;
    logic [NPINS-1:0]   clr_vec;

    gsu_regs #(
        .NPINS     (NPINS),
        .ADDR_W    (ADDR_W),
        .UPPER_OFS (UPPER_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status_q),
        .bus_rdata (bus_rdata),
        .enable_q  (enable_q),
        .type_q    (type_q),
        .clr_vec   (clr_vec)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_cfg_t cfg;
        assign cfg.both     = type_q[2*NPINS + i];
        assign cfg.edge_sel = type_q[NPINS + i];
        assign cfg.pol      = type_q[i];

        gsu_sense_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_i[i]),
            .cfg   (cfg),
            .clr   (clr_vec[i]),
            .pend  (status_q[i])
        );
    end

    assign irq_o = |(status_q & enable_q);

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
    parameter int N         = 8,
    parameter int AW        = 12,
    parameter int UPPER_OFS = 'h80
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  pin_i,
    input logic [N-1:0]  st,
    input logic [N-1:0]  en,
    input logic [2*N-1:0] typ,
    input logic [N-1:0]  clr,
    input logic          irq,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [N-1:0]  wmask
);
    localparam logic [AW-1:0] A_MENB = AW'(UPPER_OFS + gsu_pkg::OFS_ENB);

    logic [N-1:0] edg;
    logic [N-1:0] lvl_act;

    assign edg     = typ[2*N-1:N];
    assign lvl_act = ~(pin_i ^ typ[N-1:0]);

    // R2: a pending edge pin that is not cleared stays pending
    a_r2_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st & edg & ~clr) & ~st) == '0));

    // R5: a level pin's status equals the level seen one clock earlier
    a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st ^ $past(lvl_act)) & ~$past(edg)) == '0));

    // R7: no request while every pin is disabled
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

    // R7: a request always has a pending pin behind it
    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st != '0));

    // R8: masked enable write leaves unmasked bits alone
    a_r8_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MENB) |=> (((en ^ $past(en)) & ~$past(wmask)) == '0));

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(
    .N         (NPINS),
    .AW        (ADDR_W),
    .UPPER_OFS (UPPER_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .st       (status_q),
    .en       (enable_q),
    .typ      (type_q[2*NPINS-1:0]),
    .clr      (clr_vec),
    .irq      (irq_o),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wmask    (bus_wdata[2*NPINS-1:NPINS])
);

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int AW = 12;
    localparam int DW = 3 * N;

    localparam logic [AW-1:0] A_STAT = 12'h040;
    localparam logic [AW-1:0] A_ENB  = 12'h050;
    localparam logic [AW-1:0] A_TYPE = 12'h060;
    localparam logic [AW-1:0] A_CLR  = 12'h070;
    localparam logic [AW-1:0] A_MENB = 12'h0D0;
    localparam logic [AW-1:0] A_MTYP = 12'h0E0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_i = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    bit            q_irq[$];
    logic [DW-1:0] q_exp[$];
    logic [AW-1:0] q_addr[$];
    string         q_req[$];

    gpio_irq_sense #(.NPINS(N), .ADDR_W(AW), .UPPER_OFS('h80)) u_gpio_irq_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare each queued expectation mid-cycle
    always @(negedge clk) begin
        if (q_exp.size() != 0) begin
            bit            is_irq;
            logic [DW-1:0] e;
            logic [DW-1:0] act;
            logic [AW-1:0] a;
            string         r;
            is_irq = q_irq.pop_front();
            e = q_exp.pop_front();
            a = q_addr.pop_front();
            r = q_req.pop_front();
            act = is_irq ? DW'(irq_o) : bus_rdata;
            checks++;
            if (act !== e) begin
                fails++;
                if (is_irq) $display("FAIL %s irq_o actual=%0h expected=%0h", r, act, e);
                else $display("FAIL %s addr=%03h actual=%06h expected=%06h", r, a, act, e);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d cycles expected<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic exp_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string r);
        bus_addr = a;
        q_irq.push_back(1'b0); q_exp.push_back(e); q_addr.push_back(a); q_req.push_back(r);
        @(posedge clk); #1;
    endtask

    task automatic exp_irq(input logic e, input string r);
        q_irq.push_back(1'b1); q_exp.push_back(DW'(e)); q_addr.push_back('0); q_req.push_back(r);
        @(posedge clk); #1;
    endtask

    task automatic pins(input logic [N-1:0] v);
        pin_i = v;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        exp_rd(A_STAT, 24'h000000, "R1");
        exp_rd(A_ENB,  24'h000000, "R1");
        exp_rd(A_TYPE, 24'h00FFFF, "R1");
        exp_irq(1'b0, "R1");

        // R2 rising edge, R7 status with enable off
        pins(8'h01);
        exp_rd(A_STAT, 24'h000001, "R2");
        exp_irq(1'b0, "R7");
        wr(A_ENB, 24'h000001);
        exp_irq(1'b1, "R7");
        exp_rd(A_ENB, 24'h000001, "R10");
        pins(8'h00);
        exp_rd(A_STAT, 24'h000001, "R2");

        // R6 clear with zero, then with one
        wr(A_CLR, 24'h000000);
        exp_rd(A_STAT, 24'h000001, "R6");
        wr(A_CLR, 24'h000001);
        exp_rd(A_STAT, 24'h000000, "R6");
        exp_irq(1'b0, "R7");

        // R10 status ignores writes
        wr(A_STAT, 24'h0000FF);
        exp_rd(A_STAT, 24'h000000, "R10");

        // R3 falling edge on pin 1
        wr(A_TYPE, 24'h00FFFD);
        exp_rd(A_TYPE, 24'h00FFFD, "R10");
        pins(8'h02);
        exp_rd(A_STAT, 24'h000000, "R3");
        pins(8'h00);
        exp_rd(A_STAT, 24'h000002, "R3");
        wr(A_CLR, 24'h000002);

        // R4 both edges on pin 2
        wr(A_TYPE, 24'h04FFF9);
        pins(8'h04);
        exp_rd(A_STAT, 24'h000004, "R4");
        wr(A_CLR, 24'h000004);
        exp_rd(A_STAT, 24'h000000, "R4");
        pins(8'h00);
        exp_rd(A_STAT, 24'h000004, "R4");
        wr(A_CLR, 24'h000004);

        // R5 level high on pin 3
        wr(A_TYPE, 24'h04F7F9);
        exp_rd(A_STAT, 24'h000000, "R5");
        pins(8'h08);
        exp_rd(A_STAT, 24'h000008, "R5");
        wr(A_CLR, 24'h000008);
        exp_rd(A_STAT, 24'h000008, "R5");
        pins(8'h00);
        exp_rd(A_STAT, 24'h000000, "R5");

        // R5 level low on pin 4
        wr(A_TYPE, 24'h04E7E9);
        pins(8'h00);
        exp_rd(A_STAT, 24'h000010, "R5");
        pins(8'h10);
        exp_rd(A_STAT, 24'h000000, "R5");

        // R6 clear and new edge on the same clock
        pins(8'h11);
        pins(8'h10);
        exp_rd(A_STAT, 24'h000001, "R6");
        pin_i = 8'h11;
        wr(A_CLR, 24'h000001);
        exp_rd(A_STAT, 24'h000001, "R6");
        wr(A_CLR, 24'h000001);
        exp_rd(A_STAT, 24'h000000, "R6");

        // R8 masked enable
        wr(A_MENB, 24'h000CF4);
        exp_rd(A_ENB, 24'h000005, "R8");
        wr(A_MENB, 24'h000100);
        exp_rd(A_ENB, 24'h000004, "R8");

        // R9 masked type touches the polarity lane only
        wr(A_MTYP, 24'h001010);
        exp_rd(A_TYPE, 24'h04E7F9, "R9");
        exp_rd(A_STAT, 24'h000010, "R9");
        exp_irq(1'b0, "R7");
        wr(A_MENB, 24'h001010);
        exp_irq(1'b1, "R8");
        exp_rd(A_ENB, 24'h000014, "R8");

        // R10 write-only and alias addresses read zero
        exp_rd(A_CLR,  24'h000000, "R10");
        exp_rd(A_MENB, 24'h000000, "R10");
        exp_rd(A_MTYP, 24'h000000, "R10");

        @(posedge clk); #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule